// File: doc/BRIEF.md
# Bus-Cycle Serial Memory Sequencer

This block is the device-side engine of a 512 x 8 byte store that a processor reaches with ordinary bus cycles, through a chip enable, an output enable and a write enable plus a single data bit. All three strobes and the data bit are resynchronised into the system clock. The block then sorts each bus cycle into a read, a write or an illegal cycle. The order of those cycles carries all control: an in-band restart pattern, a serial address frame, a byte stream served bit by bit, and a page of data bits that goes to a separate commit block.

Once a full address frame has arrived, read cycles return the addressed byte one bit at a time, starting with the most significant bit. The address advances after every byte and runs past the top of the store back to zero. If write cycles follow the frame, each one is passed to the commit block as a page-data bit. A read, a write of 1 and another read then ask the commit block to start a nonvolatile write. That request is only made when the page holds whole bytes. While the commit block reports a write in progress, every read returns 0 and no bus cycle has any effect on the sequencer. The commit block also owns the write port of the store.

Top module: `buscyc_serial_seq`

## Requirements
- R1: After reset, dq_oe is 0 while no read cycle is active, illegal_seen is 0, and a read cycle returns 1.
- R2: dq_oe is 1 only while both ce_n and oe_n, after synchronisation, are low. It is 0 when only one of them is low.
- R3: A frame of 16 write cycles with no read between them loads the address, most significant bit first. The first 7 bits are ignored and the last 9 bits are the byte address. The next 8 read cycles return that byte, most significant bit first.
- R4: After the eighth bit of a byte has been read, the address increments and wraps from 0x1FF to 0x000. The next read cycles return the following byte.
- R5: The pattern read, write of 0, read restarts the sequencer when its write completes, even in the middle of a byte being read. The second read of the pattern, and every read after it, returns 1 until a new address frame has loaded.
- R6: A read cycle during an address frame discards the partial frame and returns 1. A later frame must carry all 16 bits again.
- R7: Write cycles that directly follow a loaded address each produce a one-cycle pg_wr pulse, with the bit on pg_bit, in bus order. ld_addr holds the loaded address.
- R8: After a page load, the pattern read, write of 1, read raises wr_start for exactly one cycle. This happens only if the page bit count is a nonzero multiple of 8; otherwise no wr_start follows.
- R9: While nv_busy is 1, every read cycle returns 0 and no bus cycle, including a restart pattern, changes the sequencer. Reading carries on from the same bit once nv_busy falls.
- R10: A cycle with ce_n, we_n and oe_n all low is ignored, so it adds no address or data bit. It sets illegal_seen, which stays 1 until reset.
- R11: A write cycle stores the value of dq_in present when the cycle ends, that is, when the first of we_n or ce_n rises. Earlier values within the cycle do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| dq_in | input | 1 | Incoming serial data bit |
| dq_out | output | 1 | Outgoing serial data bit |
| dq_oe | output | 1 | Drive enable for dq_out |
| nv_busy | input | 1 | Commit block reports a nonvolatile write in progress |
| pg_wr | output | 1 | One-cycle pulse per page-data bit |
| pg_bit | output | 1 | Page-data bit value, valid with pg_wr |
| ld_addr | output | 9 | Currently loaded byte address |
| wr_start | output | 1 | One-cycle request to start the nonvolatile write |
| mem_we | input | 1 | Store write strobe from the commit block |
| mem_waddr | input | 9 | Store write address |
| mem_wdata | input | 8 | Store write data |
| illegal_seen | output | 1 | Sticky flag for illegal bus cycles |

## Verification
The byte stream is read at a mid-store address, across one byte boundary, and across the top of the store. Together these separate bit order, the increment and the wrap. Restart patterns are sent in the middle of a byte and during a busy window, which separates a restart that acts from one that must be ignored. A frame broken by a read, and a frame with an illegal cycle in it, show whether bits are counted only from legal, uninterrupted writes. A whole-byte page and a partial page show whether the write-start request depends on the bit count. Data bits that change value inside a cycle show whether the bit is taken from the end of the cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // kind of the bus cycle currently seen on the synchronised strobes
  typedef enum logic [1:0] {
    CY_IDLE,
    CY_WR,
    CY_RD,
    CY_BAD
  } cyc_e;

  // protocol position of the sequencer
  typedef enum logic [2:0] {
    ST_IDLE,    // unaddressed, reads return 1
    ST_ADDR,    // shifting an address frame
    ST_LOADED,  // frame complete, nothing moved yet
    ST_READ,    // serving bytes
    ST_PAGE,    // collecting page-data bits
    ST_PEND,    // page closed by a read
    ST_ARM      // write of 1 seen, waiting for the closing read
  } seq_e;
endpackage

// File: rtl/bcs_cycle_classify.sv
module bcs_cycle_classify
  import bcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic dq_in,
  output logic ce_s,
  output logic oe_s,
  output logic we_s,
  output logic wr_evt,
  output logic wr_bit,
  output logic rd_evt,
  output logic illegal_seen
);
  localparam int NSIG = 4;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] pipe [SYNC_STAGES];
  logic            dq_s;

  assign raw = {dq_in, we_n, oe_n, ce_n};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= '1;
      else if (s == 0) pipe[s] <= raw;
      else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
    end
  end

  assign {dq_s, we_s, oe_s, ce_s} = pipe[SYNC_STAGES-1];

  cyc_e now_k, cyc_q;
  logic bit_q;

  always_comb begin
    now_k = CY_IDLE;
    if (!ce_s) begin
      if (!we_s && !oe_s) now_k = CY_BAD;
      else if (!we_s)     now_k = CY_WR;
      else if (!oe_s)     now_k = CY_RD;
    end
  end

  // a cycle ends when its kind goes away; a cycle spoiled into BAD never ends as legal
  assign wr_evt = (cyc_q == CY_WR) && (now_k != CY_WR) && (now_k != CY_BAD);
  assign rd_evt = (cyc_q == CY_RD) && (now_k != CY_RD) && (now_k != CY_BAD);
  assign wr_bit = bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q        <= CY_IDLE;
      bit_q        <= 1'b1;
      illegal_seen <= 1'b0;
    end else begin
      if (now_k == CY_BAD) begin
        cyc_q        <= CY_BAD;
        illegal_seen <= 1'b1;
      end else if (cyc_q == CY_BAD && now_k != CY_IDLE) begin
        cyc_q <= CY_BAD;
      end else begin
        cyc_q <= now_k;
      end
      if (now_k == CY_WR) bit_q <= dq_s;
    end
  end

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_seen |=> illegal_seen);

  a_r11_last_value: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> (wr_bit == $past(dq_s)));
endmodule

// File: rtl/bcs_byte_store.sv
module bcs_byte_store #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/bcs_protocol.sv
module bcs_protocol
  import bcs_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int FRAME_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              wr_bit,
  input  logic              rd_evt,
  input  logic              nv_busy,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              dq_val,
  output logic              pg_wr,
  output logic              pg_bit,
  output logic              wr_start
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] MSB_IDX  = BIT_W'(DATA_W - 1);

  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);   // natural wrap at the top of the store
  endfunction

  function automatic logic [BIT_W-1:0] pg_count_next(input logic [BIT_W-1:0] c);
    return (c == MSB_IDX) ? '0 : c + BIT_W'(1);
  endfunction

  seq_e              state;
  logic              last_rd;
  logic [CNT_W-1:0]  acnt;
  logic [ADDR_W-1:0] addr_q;
  logic [BIT_W-1:0]  bitptr;
  logic [BIT_W-1:0]  pg_cnt;
  logic              pg_any;

  // named internal events for the assertions
  logic ev, rst_hit, serving, rd_adv, commit_ok;

  assign ev        = (wr_evt | rd_evt) & ~nv_busy;
  assign rst_hit   = ev & wr_evt & ~wr_bit & last_rd & (state != ST_IDLE);
  assign serving   = (state == ST_LOADED) || (state == ST_READ);
  assign rd_adv    = ev & rd_evt & serving;
  assign commit_ok = pg_any && (pg_cnt == '0);

  assign rd_addr = addr_q;
  assign dq_val  = nv_busy ? 1'b0 : (serving ? rd_byte[bitptr] : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      last_rd  <= 1'b0;
      acnt     <= '0;
      addr_q   <= '0;
      bitptr   <= MSB_IDX;
      pg_cnt   <= '0;
      pg_any   <= 1'b0;
      pg_wr    <= 1'b0;
      pg_bit   <= 1'b0;
      wr_start <= 1'b0;
    end else begin
      pg_wr    <= 1'b0;
      wr_start <= 1'b0;
      if (ev) begin
        last_rd <= rd_evt;
        if (rst_hit) begin
          state <= ST_IDLE;
        end else begin
          unique case (state)
            ST_IDLE: if (wr_evt) begin
              state  <= ST_ADDR;
              acnt   <= CNT_W'(1);
              addr_q <= {addr_q[ADDR_W-2:0], wr_bit};
            end
            ST_ADDR: if (wr_evt) begin
              addr_q <= {addr_q[ADDR_W-2:0], wr_bit};
              acnt   <= acnt + CNT_W'(1);
              if (acnt == LAST_BIT) begin
                state  <= ST_LOADED;
                bitptr <= MSB_IDX;
              end
            end else begin
              state <= ST_IDLE;
            end
            ST_LOADED, ST_READ: if (rd_evt) begin
              state <= ST_READ;
              if (bitptr == '0) begin
                bitptr <= MSB_IDX;
                addr_q <= addr_next(addr_q);
              end else begin
                bitptr <= bitptr - BIT_W'(1);
              end
            end else if (state == ST_LOADED) begin
              state  <= ST_PAGE;
              pg_wr  <= 1'b1;
              pg_bit <= wr_bit;
              pg_cnt <= BIT_W'(1);
              pg_any <= 1'b1;
            end
            ST_PAGE: if (wr_evt) begin
              pg_wr  <= 1'b1;
              pg_bit <= wr_bit;
              pg_cnt <= pg_count_next(pg_cnt);
            end else begin
              state <= ST_PEND;
            end
            ST_PEND: if (wr_evt) state <= ST_ARM;
            ST_ARM: begin
              if (rd_evt && commit_ok) wr_start <= 1'b1;
              state  <= ST_IDLE;
              pg_any <= 1'b0;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  a_r4_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv && bitptr == '0 && addr_q == '1) |=> (addr_q == '0));

  a_r9_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> ($stable(state) && $stable(addr_q) && $stable(bitptr)));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> (!wr_start && state == ST_IDLE));

  a_r7_pulse_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    pg_wr |-> (state == ST_PAGE));
endmodule

// File: rtl/buscyc_serial_seq.sv
module buscyc_serial_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int FRAME_BITS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              dq_in,
  output logic              dq_out,
  output logic              dq_oe,
  input  logic              nv_busy,
  output logic              pg_wr,
  output logic              pg_bit,
  output logic [ADDR_W-1:0] ld_addr,
  output logic              wr_start,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_waddr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic              illegal_seen
);
  logic ce_s, oe_s, we_s;
  logic wr_evt, wr_bit, rd_evt;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_byte;
  logic dq_val;

  bcs_cycle_classify #(.SYNC_STAGES(SYNC_STAGES)) u_cls (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .dq_in(dq_in),
    .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s),
    .wr_evt(wr_evt), .wr_bit(wr_bit), .rd_evt(rd_evt), .illegal_seen(illegal_seen)
  );

  bcs_byte_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .wr_en(mem_we), .wr_addr(mem_waddr), .wr_data(mem_wdata),
    .rd_addr(rd_addr), .rd_data(rd_byte)
  );

  bcs_protocol #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS)) u_proto (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_bit(wr_bit), .rd_evt(rd_evt),
    .nv_busy(nv_busy), .rd_byte(rd_byte), .rd_addr(rd_addr), .dq_val(dq_val),
    .pg_wr(pg_wr), .pg_bit(pg_bit), .wr_start(wr_start)
  );

  logic unused_we_s;
  assign unused_we_s = we_s;

  assign dq_oe   = !ce_s && !oe_s;
  assign dq_out  = dq_val;
  assign ld_addr = rd_addr;

  a_r2_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!$past(ce_n, SYNC_STAGES) && !$past(oe_n, SYNC_STAGES)));

  a_r9_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_busy && dq_oe) |-> !dq_out);
endmodule

// File: tb/buscyc_serial_seq_tb.sv
module buscyc_serial_seq_tb;
  localparam int AW = 9, DW = 8, HOLD = 4;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, dq_in = 1, nv_busy = 0;
  logic mem_we = 0;
  logic [AW-1:0] mem_waddr = '0;
  logic [DW-1:0] mem_wdata = '0;
  logic dq_out, dq_oe, pg_wr, pg_bit, wr_start, illegal_seen;
  logic [AW-1:0] ld_addr;

  buscyc_serial_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .nv_busy(nv_busy), .pg_wr(pg_wr), .pg_bit(pg_bit),
    .ld_addr(ld_addr), .wr_start(wr_start), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .illegal_seen(illegal_seen)
  );

  always #4 clk = ~clk;   // 125 MHz

  int checks = 0, errors = 0;
  typedef struct { logic bitv; string tag; } exp_t;
  exp_t exp_q[$];
  int req_cnt = 0, done_cnt = 0;
  int pg_cnt = 0, ws_cnt = 0;
  logic [63:0] pg_hist = '0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    while (done_cnt < req_cnt) begin
      exp_t e;
      e = exp_q.pop_front();
      done_cnt++;
      checks++;
      if (!(dq_oe === 1'b1 && dq_out === e.bitv)) begin
        errors++;
        $display("FAIL %s: actual dq_oe=%0d dq_out=%0d expected dq_oe=1 dq_out=%0d",
                 e.tag, dq_oe, dq_out, e.bitv);
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (pg_wr) begin
        pg_hist <= {pg_hist[62:0], pg_bit};
        pg_cnt  <= pg_cnt + 1;
      end
      if (wr_start) ws_cnt <= ws_cnt + 1;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic b, input bit late = 0);
    @(negedge clk);
    dq_in = late ? ~b : b; ce_n = 0; we_n = 0;
    repeat (HOLD) @(negedge clk);
    if (late) begin dq_in = b; repeat (HOLD) @(negedge clk); end
    we_n = 1; ce_n = 1;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic rd(input bit use_chk, input logic e, input string tag);
    @(negedge clk);
    ce_n = 0; oe_n = 0;
    repeat (HOLD) @(negedge clk);
    if (use_chk) begin
      exp_q.push_back('{e, tag});
      @(posedge clk);
      req_cnt++;
      @(negedge clk);
    end
    oe_n = 1; ce_n = 1;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic restart();
    rd(0, 1'b0, "");
    wr(1'b0);
    rd(0, 1'b0, "");
  endtask

  task automatic load_addr(input int a, input logic [6:0] junk, input int bad_at = -1);
    for (int i = 15; i >= 0; i--) begin
      logic [15:0] fr;
      fr = {junk, 9'(a)};
      if (i == bad_at) begin
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 0;
        repeat (HOLD) @(negedge clk);
        ce_n = 1; we_n = 1; oe_n = 1;
        repeat (HOLD) @(negedge clk);
      end
      wr(fr[i]);
    end
  endtask

  task automatic read_bits(input int a, input int hi, input int lo, input string tag);
    logic [7:0] d;
    d = pat(a);
    for (int i = hi; i >= lo; i--) rd(1, d[i], tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    idle(3);
    rst_n = 1;
    idle(4);
    // R1: reset state
    chk(dq_oe == 0, "R1 dq_oe", dq_oe, 0);
    chk(illegal_seen == 0, "R1 illegal_seen", illegal_seen, 0);
    rd(1, 1'b1, "R1 read after reset");

    // preload the store through the commit-side port
    for (int a = 0; a < 512; a++) begin
      @(negedge clk);
      mem_we = 1; mem_waddr = AW'(a); mem_wdata = pat(a);
    end
    @(negedge clk); mem_we = 0;

    // R2: only one of the two strobes low
    oe_n = 0; idle(HOLD);
    chk(dq_oe == 0, "R2 oe alone", dq_oe, 0);
    oe_n = 1; ce_n = 0; idle(HOLD);
    chk(dq_oe == 0, "R2 ce alone", dq_oe, 0);
    ce_n = 1; idle(HOLD);

    // R3 frame with junk upper bits, R4 increment, R5 restart mid-byte
    restart();
    load_addr(9'h0A5, 7'h7F);
    chk(ld_addr == 9'h0A5, "R3 ld_addr", ld_addr, 9'h0A5);
    read_bits(9'h0A5, 7, 0, "R3");
    read_bits(9'h0A6, 7, 0, "R4 increment");
    read_bits(9'h0A7, 7, 3, "R5 pre-restart");
    wr(1'b0);
    rd(1, 1'b1, "R5 second read");
    rd(1, 1'b1, "R5 later read");

    // R4 wrap
    restart();
    load_addr(9'h1FF, 7'h2A);
    read_bits(9'h1FF, 7, 0, "R4 top");
    read_bits(9'h000, 7, 0, "R4 wrap");

    // R6 broken frame
    restart();
    for (int i = 0; i < 5; i++) wr(1'b1);
    rd(1, 1'b1, "R6 abort read");
    rd(1, 1'b1, "R6 still idle");
    load_addr(9'h0F0, 7'h00);
    read_bits(9'h0F0, 7, 0, "R6 fresh frame");

    // R7 page load with late-settling data (R11), R8 commit
    restart();
    load_addr(9'h123, 7'h11);
    base = pg_cnt;
    for (int i = 15; i >= 0; i--) begin
      logic [15:0] pd;
      pd = 16'hC35A;
      wr(pd[i], (i % 2) == 1);
    end
    idle(4);
    chk(pg_cnt - base == 16, "R7 pulse count", pg_cnt - base, 16);
    chk(pg_hist[15:0] == 16'hC35A, "R11 page bits", int'(pg_hist[15:0]), 16'hC35A);
    chk(ld_addr == 9'h123, "R7 ld_addr", ld_addr, 9'h123);
    rd(0, 1'b0, ""); wr(1'b1); rd(0, 1'b0, "");
    idle(4);
    chk(ws_cnt == 1, "R8 whole page", ws_cnt, 1);
    rd(1, 1'b1, "R8 idle after commit");

    // R8 partial page: no request
    restart();
    load_addr(9'h040, 7'h00);
    for (int i = 0; i < 5; i++) wr(1'b1);
    rd(0, 1'b0, ""); wr(1'b1); rd(0, 1'b0, "");
    idle(4);
    chk(ws_cnt == 1, "R8 partial page", ws_cnt, 1);

    // R9 busy window
    restart();
    load_addr(9'h0A0, 7'h05);
    read_bits(9'h0A0, 7, 5, "R9 before busy");
    @(negedge clk); nv_busy = 1;
    rd(1, 1'b0, "R9 busy read");
    wr(1'b0);
    rd(1, 1'b0, "R9 busy read after write");
    @(negedge clk); nv_busy = 0;
    read_bits(9'h0A0, 4, 0, "R9 resume");

    // R10 illegal cycle inside a frame
    restart();
    chk(illegal_seen == 0, "R10 flag clear", illegal_seen, 0);
    load_addr(9'h155, 7'h33, 7);
    chk(illegal_seen == 1, "R10 flag set", illegal_seen, 1);
    read_bits(9'h155, 7, 0, "R10 frame intact");
    restart();
    chk(illegal_seen == 1, "R10 flag sticky", illegal_seen, 1);

    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule